// File: doc/BRIEF.md
# Video-Line Edge-Counting Interrupt Counter

This block raises a raster interrupt for the CPU after a programmed number of video lines. It watches the video address line A12, which rises once per rendered line. Each qualified rising edge updates an 8-bit down-counter. When the counter reaches zero while interrupts are enabled, an active-low request line is asserted. The line stays low until software acknowledges it.

Software programs the block through a small write port that decodes address bits 15..13 and bit 0. The register pairs are: a reload latch and a counter-clear command at 0xC000/0xC001, and an interrupt disable/acknowledge and an interrupt enable at 0xE000/0xE001. A mode input selects an alternate zero rule. In that mode a counter that reloads from zero back to zero stays silent, unless the reload was forced by an explicit clear. A12 is brought into the system clock domain by a synchronizer. A rising edge only counts after A12 has been low for a minimum number of clocks, so short glitches are rejected.

Top module: `a12IrqCounter`

## Requirements
- R1: A write with address bits 15..13 = 3'b110 and bit 0 = 0 (0xC000) stores the data byte in the reload latch. The stored value is used at the next edge that reloads the counter.
- R2: A write with bits 15..13 = 3'b110 and bit 0 = 1 (0xC001) forces the counter to zero. When the mode input is 1, the same write also sets the one-shot clear flag.
- R3: On each qualified A12 edge, the counter loads the reload latch if it is zero or the clear flag is set. Otherwise it decrements by one.
- R4: After the R3 update, an interrupt is requested if the counter is zero and interrupts are enabled.
- R5: `irqN` is active low. Once asserted it stays low until a write to bits 15..13 = 3'b111 with bit 0 = 0 (0xE000) or a reset. That same write also disables interrupts.
- R6: A write to bits 15..13 = 3'b111 with bit 0 = 1 (0xE001) enables interrupts. While interrupts are disabled, a counter reaching zero raises no request.
- R7: With the mode input at 1, a request additionally needs the counter to have been nonzero before the edge, or the clear flag to have been set.
- R8: The clear flag is dropped at the end of every qualified edge, so it affects only the next edge.
- R9: After reset the reload latch is 255, the counter is 0, the clear flag is off, interrupts are disabled and `irqN` is high.
- R10: Only a low-to-high transition of the synchronized A12 counts. It counts only if A12 was low for at least 3 clocks just before the transition; a low run of 2 clocks is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrite | input | 1 | One-cycle CPU write strobe |
| regAddrHi | input | 3 | CPU address bits 15..13 |
| regAddrLo | input | 1 | CPU address bit 0 |
| regData | input | 8 | CPU write data |
| a12In | input | 1 | Asynchronous video address line A12 |
| altMode | input | 1 | 1 selects the alternate zero rule |
| irqN | output | 1 | Active-low sticky interrupt request |

## Verification
The counting path is driven with short reload values, so each edge's effect on the count is seen directly in whether the request appears exactly on the expected edge and not on the one before it. A reload of zero is tried in both modes: plain repeated edges tell the normal and alternate zero rules apart, and an explicit clear shows the one-shot flag re-arming a single request. A12 low runs of 2 and 3 clocks separate a rejected glitch from a counted edge. A full 256-edge run from reset confirms the reset reload value of 255.

// File: rtl/a12IrqPkg.sv
package a12IrqPkg;
  typedef struct packed {
    logic wrReload;
    logic wrClear;
    logic wrDisable;
    logic wrEnable;
    logic a12Edge;
  } ctrlStrobes_t;
endpackage

// File: rtl/a12IrqCtrl.sv
module a12IrqCtrl
  import a12IrqPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LOW_MIN     = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         regWrite,
  input  logic [2:0]   regAddrHi,
  input  logic         regAddrLo,
  input  logic         a12In,
  output ctrlStrobes_t strb
);
  localparam int LW = $clog2(LOW_MIN + 1);
  localparam logic [LW-1:0] LOW_LIM = LW'(LOW_MIN);
  localparam logic [2:0] PAGE_CNT = 3'b110;
  localparam logic [2:0] PAGE_IRQ = 3'b111;

  logic [SYNC_STAGES-1:0] syncQ;
  logic a12Sync, a12Prev;
  logic [LW-1:0] lowCnt;

  generate
    if (SYNC_STAGES == 1) begin : gSync1
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= a12In;
      end
    end else begin : gSyncN
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], a12In};
      end
    end
  endgenerate

  assign a12Sync = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      a12Prev <= 1'b0;
      lowCnt  <= '0;
    end else begin
      a12Prev <= a12Sync;
      if (a12Sync)               lowCnt <= '0;
      else if (lowCnt < LOW_LIM) lowCnt <= lowCnt + 1'b1;
    end
  end

  always_comb begin
    strb           = '0;
    strb.a12Edge   = a12Sync && !a12Prev && (lowCnt >= LOW_LIM);
    strb.wrReload  = regWrite && (regAddrHi == PAGE_CNT) && !regAddrLo;
    strb.wrClear   = regWrite && (regAddrHi == PAGE_CNT) &&  regAddrLo;
    strb.wrDisable = regWrite && (regAddrHi == PAGE_IRQ) && !regAddrLo;
    strb.wrEnable  = regWrite && (regAddrHi == PAGE_IRQ) &&  regAddrLo;
  end
endmodule

// File: rtl/a12IrqDatapath.sv
module a12IrqDatapath
  import a12IrqPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strb,
  input  logic [CNT_W-1:0] regData,
  input  logic             altMode,
  output logic [CNT_W-1:0] cnt,
  output logic             clrFlag,
  output logic             irqPend
);
  localparam logic [CNT_W-1:0] RELOAD_RST = '1;

  logic [CNT_W-1:0] reloadVal, nextCnt;
  logic irqEn, fire;

  always_comb begin
    nextCnt = ((cnt == '0) || clrFlag) ? reloadVal : cnt - 1'b1;
    fire    = strb.a12Edge && (nextCnt == '0) && irqEn &&
              (!altMode || (cnt != '0) || clrFlag);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadVal <= RELOAD_RST;
      cnt       <= '0;
      clrFlag   <= 1'b0;
      irqEn     <= 1'b0;
      irqPend   <= 1'b0;
    end else begin
      if (strb.a12Edge) begin
        cnt     <= nextCnt;
        clrFlag <= 1'b0;
      end
      if (fire)          irqPend   <= 1'b1;
      if (strb.wrReload) reloadVal <= regData;
      if (strb.wrClear) begin
        cnt <= '0;
        if (altMode) clrFlag <= 1'b1;
      end
      if (strb.wrDisable) begin
        irqEn   <= 1'b0;
        irqPend <= 1'b0;
      end
      if (strb.wrEnable) irqEn <= 1'b1;
    end
  end
endmodule

// File: rtl/a12IrqCounter.sv
module a12IrqCounter
  import a12IrqPkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int LOW_MIN     = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrite,
  input  logic [2:0]       regAddrHi,
  input  logic             regAddrLo,
  input  logic [CNT_W-1:0] regData,
  input  logic             a12In,
  input  logic             altMode,
  output logic             irqN
);
  ctrlStrobes_t strb;
  logic [CNT_W-1:0] cnt;
  logic clrFlag, irqPend;

  a12IrqCtrl #(.SYNC_STAGES(SYNC_STAGES), .LOW_MIN(LOW_MIN)) ctrlU (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .regAddrHi(regAddrHi),
    .regAddrLo(regAddrLo), .a12In(a12In), .strb(strb)
  );

  a12IrqDatapath #(.CNT_W(CNT_W)) dpU (
    .clk(clk), .rstN(rstN), .strb(strb), .regData(regData),
    .altMode(altMode), .cnt(cnt), .clrFlag(clrFlag), .irqPend(irqPend)
  );

  assign irqN = !irqPend;
endmodule

// File: rtl/a12IrqCounterChk.sv
module a12IrqCounterChk
  import a12IrqPkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input ctrlStrobes_t     strb,
  input logic [CNT_W-1:0] cnt,
  input logic             clrFlag,
  input logic             irqN
);
  // R2: a clear write with no edge leaves the counter at zero
  p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrClear && !strb.a12Edge) |=> (cnt == '0));

  // R3: plain edge on a nonzero counter decrements it
  p_decrement_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.a12Edge && !strb.wrClear && cnt != '0 && !clrFlag)
      |=> (cnt == $past(cnt) - 1'b1));

  // R4: the request only appears right after a qualified edge
  p_fire_on_edge_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqN) |-> $past(strb.a12Edge));

  // R5: request is sticky until acknowledged
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!irqN && !strb.wrDisable) |=> !irqN);

  // R5: acknowledge releases the line
  p_ack_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrDisable |=> irqN);

  // R8: the clear flag is gone after an edge without a new clear
  p_flag_oneshot_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.a12Edge && !strb.wrClear) |=> !clrFlag);

  // R10: qualified edges never come in consecutive cycles
  p_edge_spacing_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.a12Edge |=> !strb.a12Edge);
endmodule

bind a12IrqCounter a12IrqCounterChk #(.CNT_W(CNT_W)) chkU (
  .clk(clk), .rstN(rstN), .strb(strb), .cnt(cnt), .clrFlag(clrFlag), .irqN(irqN)
);

// File: tb/tb_a12IrqCounter.sv
`timescale 1ns/1ps
module tb_a12IrqCounter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrite = 1'b0;
  logic [2:0] regAddrHi = 3'b000;
  logic regAddrLo = 1'b0;
  logic [7:0] regData = 8'h00;
  logic a12In = 1'b0;
  logic altMode = 1'b0;
  logic irqN;
  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = !clk;

  a12IrqCounter dut (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .regAddrHi(regAddrHi),
    .regAddrLo(regAddrLo), .regData(regData), .a12In(a12In),
    .altMode(altMode), .irqN(irqN)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] hi, input logic lo, input logic [7:0] d);
    @(negedge clk);
    regWrite = 1'b1; regAddrHi = hi; regAddrLo = lo; regData = d;
    @(negedge clk);
    regWrite = 1'b0;
    cyc(2);
  endtask

  task automatic edgeA12(input int lows);
    @(negedge clk);
    a12In = 1'b0;
    cyc(lows);
    a12In = 1'b1;
    cyc(6);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    altMode = 1'b0;
    a12In = 1'b0;
    cyc(3);
    rstN = 1'b1;
    cyc(2);
  endtask

  task automatic testReset();
    check(irqN === 1'b1, "R9 reset irqN", int'(irqN), 1);
  endtask

  task automatic testBasic();
    wr(3'b110, 1'b0, 8'd2);
    wr(3'b110, 1'b1, 8'd0);
    wr(3'b111, 1'b1, 8'd0);
    edgeA12(5);
    check(irqN === 1'b1, "R3 edge1 reload", int'(irqN), 1);
    edgeA12(5);
    check(irqN === 1'b1, "R1 edge2 count 1", int'(irqN), 1);
    edgeA12(5);
    check(irqN === 1'b0, "R4 edge3 fires", int'(irqN), 0);
  endtask

  task automatic testSticky();
    edgeA12(5);
    check(irqN === 1'b0, "R5 stays low", int'(irqN), 0);
    wr(3'b111, 1'b1, 8'd0);
    check(irqN === 1'b0, "R5 enable no ack", int'(irqN), 0);
    wr(3'b111, 1'b0, 8'd0);
    check(irqN === 1'b1, "R5 ack releases", int'(irqN), 1);
  endtask

  task automatic testDisabled();
    wr(3'b110, 1'b0, 8'd1);
    wr(3'b110, 1'b1, 8'd0);
    edgeA12(5);
    edgeA12(5);
    check(irqN === 1'b1, "R6 disabled silent", int'(irqN), 1);
    wr(3'b111, 1'b1, 8'd0);
    edgeA12(5);
    check(irqN === 1'b1, "R6 reload edge", int'(irqN), 1);
    edgeA12(5);
    check(irqN === 1'b0, "R6 enabled fires", int'(irqN), 0);
    wr(3'b111, 1'b0, 8'd0);
  endtask

  task automatic testGlitch();
    wr(3'b111, 1'b1, 8'd0);
    wr(3'b110, 1'b0, 8'd1);
    wr(3'b110, 1'b1, 8'd0);
    edgeA12(5);
    check(irqN === 1'b1, "R10 first edge", int'(irqN), 1);
    edgeA12(2);
    check(irqN === 1'b1, "R10 2-low glitch ignored", int'(irqN), 1);
    edgeA12(3);
    check(irqN === 1'b0, "R10 3-low edge counts", int'(irqN), 0);
    wr(3'b111, 1'b0, 8'd0);
  endtask

  task automatic testAlt();
    wr(3'b111, 1'b1, 8'd0);
    wr(3'b110, 1'b0, 8'd0);
    wr(3'b110, 1'b1, 8'd0);
    edgeA12(5);
    check(irqN === 1'b0, "R4 normal reload0 fires", int'(irqN), 0);
    wr(3'b111, 1'b0, 8'd0);
    wr(3'b111, 1'b1, 8'd0);
    edgeA12(5);
    check(irqN === 1'b0, "R4 normal reload0 repeats", int'(irqN), 0);
    wr(3'b111, 1'b0, 8'd0);
    wr(3'b111, 1'b1, 8'd0);
    altMode = 1'b1;
    edgeA12(5);
    check(irqN === 1'b1, "R7 alt zero-to-zero silent", int'(irqN), 1);
    wr(3'b110, 1'b1, 8'd0);
    edgeA12(5);
    check(irqN === 1'b0, "R2 alt clear flag fires", int'(irqN), 0);
    wr(3'b111, 1'b0, 8'd0);
    wr(3'b111, 1'b1, 8'd0);
    edgeA12(5);
    check(irqN === 1'b1, "R8 flag one-shot", int'(irqN), 1);
    wr(3'b110, 1'b0, 8'd1);
    edgeA12(5);
    edgeA12(5);
    check(irqN === 1'b0, "R7 alt nonzero-to-zero fires", int'(irqN), 0);
    altMode = 1'b0;
  endtask

  task automatic testResetReload();
    doReset();
    check(irqN === 1'b1, "R9 reset clears request", int'(irqN), 1);
    wr(3'b111, 1'b1, 8'd0);
    for (int k = 0; k < 255; k++) edgeA12(4);
    check(irqN === 1'b1, "R9 reload 255 not yet", int'(irqN), 1);
    edgeA12(4);
    check(irqN === 1'b0, "R9 reload 255 fires", int'(irqN), 0);
  endtask

  initial begin
    doReset();
    testReset();
    testBasic();
    testSticky();
    testDisabled();
    testGlitch();
    testAlt();
    testResetReload();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule